// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block is the host-side engine that fetches one page from a parallel NAND flash device and returns it as a stream of bytes. A single request pulse carries a row (page) address and a start column. The sequencer then drives the setup command, four address cycles and the confirm command on the shared 8-bit bus. It waits, with a timeout, for the ready/busy line to report that the page has moved into the device's data register. It then pulses the read-enable strobe once per byte, from the start column up to the last column of the page.

While bytes are streaming, the host may ask for a column change. The sequencer finishes the byte in flight, sends the column-change command pair with the new two-byte column, and carries on streaming from there without reloading the page. This can be repeated as often as needed. Every new page request always sends the full setup, address and confirm sequence. Strobe low and high widths are parameters counted in system clocks, so the bus timing can be matched to the device at any clock rate.

Top module: `nfr_page_reader`

## Requirements
- R1: An accepted request produces exactly six write-strobe cycles in this order: command 00h (cle=1, ale=0), column low byte, column high byte, row low byte, row high byte (each cle=0, ale=1), then command 30h (cle=1, ale=0). The device latches each one on the rising edge of nand_we_n. cle and ale are never high together.
- R2: nand_we_n stays low for exactly WE_LO clocks per cycle and nand_re_n stays low for exactly RE_LO clocks per byte. Successive falling edges of nand_re_n are at least RE_LO+RE_HI clocks apart.
- R3: After the confirm command, no read strobe falls until the synchronised ready/busy level is high (1 = ready).
- R4: Each read strobe yields one single-cycle out_valid with out_data equal to the byte the device drove and out_col equal to its column. Columns run consecutively from the start column to PAGE_BYTES-1. After the last byte, done pulses for one cycle and busy falls in that same cycle.
- R5: A jump_valid pulse seen while bytes stream causes the following, after the byte in flight: command 05h, the new column low and high bytes, and command E0h. Streaming then resumes at the new column. This works any number of times within one page.
- R6: jump_valid while no read is active has no effect: no strobe moves and busy stays low.
- R7: req_valid while busy is ignored. The running read keeps its row and column, and no second sequence is sent.
- R8: If ready is not seen within busy_limit clocks of the confirm command, the read is aborted. timeout rises as busy falls, no byte and no done are produced, and timeout clears when the next request is accepted.
- R9: In reset and on the cycle after it: nand_we_n=1, nand_re_n=1, cle=ale=0, nand_io_oe=0, busy=0, out_valid=0, timeout=0. A reset during a read returns the block to this state.
- R10: A page read that follows column jumps begins again with the 00h setup command.
- R11: nand_io_oe is low whenever nand_re_n is low, so the host never drives the bus while the device does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a page read (taken only when idle) |
| req_row | input | 16 | Row (page) address |
| req_col | input | COL_W | Start column |
| jump_valid | input | 1 | Change column during streaming |
| jump_col | input | COL_W | New column for a jump |
| busy_limit | input | LIMIT_W | Ready wait limit in clocks |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse after the last byte |
| timeout | output | 1 | Last read aborted on ready timeout |
| out_valid | output | 1 | out_data and out_col are valid |
| out_data | output | 8 | Byte read from the device |
| out_col | output | COL_W | Column of out_data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus value driven by host |
| nand_io_oe | output | 1 | Host drives the bus |
| nand_io_in | input | 8 | Bus value driven by device |
| nand_rb | input | 1 | Ready/busy, 1 = ready |

## Verification
A wrong step counter or sequence selector appears at once as a misordered or missing entry in the latched command/address log, before any data moves. A stuck strobe phase shows as a wrong low width on the next strobe, within one byte period. A bad column register or end test shows in the first byte after the fault as a wrong out_col or data, or as a missing or extra done. A busy-wait fault shows as a read strobe while the device is still busy, or as a timeout that comes too early or never comes.

// File: rtl/nfr_pkg.sv
`timescale 1ns/1ps
// nfr_pkg: shared types, command codes and bus-cycle encoders for the
// page read sequencer. Assumes column and row each fit in 16 bits.
package nfr_pkg;

    localparam int ROW_W = 16;

    localparam logic [7:0] CMD_RD_SETUP  = 8'h00;
    localparam logic [7:0] CMD_RD_GO     = 8'h30;
    localparam logic [7:0] CMD_COL_SETUP = 8'h05;
    localparam logic [7:0] CMD_COL_GO    = 8'hE0;

    localparam logic [2:0] RD_LAST_STEP  = 3'd5;
    localparam logic [2:0] JMP_LAST_STEP = 3'd3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_READ  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic       cle;
        logic       ale;
        logic [7:0] val;
    } bus_word_t;

    // Bus word for step n of the full page read sequence.
    function automatic bus_word_t read_word(input logic [2:0] step,
                                            input logic [15:0] col,
                                            input logic [15:0] row);
        bus_word_t w;
        case (step)
            3'd0:    w = '{cle: 1'b1, ale: 1'b0, val: CMD_RD_SETUP};
            3'd1:    w = '{cle: 1'b0, ale: 1'b1, val: col[7:0]};
            3'd2:    w = '{cle: 1'b0, ale: 1'b1, val: col[15:8]};
            3'd3:    w = '{cle: 1'b0, ale: 1'b1, val: row[7:0]};
            3'd4:    w = '{cle: 1'b0, ale: 1'b1, val: row[15:8]};
            default: w = '{cle: 1'b1, ale: 1'b0, val: CMD_RD_GO};
        endcase
        return w;
    endfunction

    // Bus word for step n of the in-page column change sequence.
    function automatic bus_word_t jump_word(input logic [2:0] step,
                                            input logic [15:0] col);
        bus_word_t w;
        case (step)
            3'd0:    w = '{cle: 1'b1, ale: 1'b0, val: CMD_COL_SETUP};
            3'd1:    w = '{cle: 1'b0, ale: 1'b1, val: col[7:0]};
            3'd2:    w = '{cle: 1'b0, ale: 1'b1, val: col[15:8]};
            default: w = '{cle: 1'b1, ale: 1'b0, val: CMD_COL_GO};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/nfr_strobe.sv
`timescale 1ns/1ps
// nfr_strobe: one active-low strobe pulse per start request, LO clocks low
// then HI clocks high. sample marks the last low clock, fin the last high
// clock. Assumes LO >= 1 and HI >= 1; start is ignored unless idle.
module nfr_strobe #(
    parameter int LO = 2,
    parameter int HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic strobe_n,
    output logic sample,
    output logic fin
);
    import nfr_pkg::*;

    localparam int MAXW = (LO > HI) ? LO : HI;
    localparam int CW   = $clog2(MAXW + 1);

    phase_t        ph;
    logic [CW-1:0] cnt;

    // Phase sequencer: idle -> low for LO clocks -> high for HI clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph  <= PH_LOW;
                        cnt <= CW'(LO - 1);
                    end
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        ph  <= PH_HIGH;
                        cnt <= CW'(HI - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) begin
                        ph <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign idle     = (ph == PH_IDLE);
    assign strobe_n = (ph != PH_LOW);
    assign sample   = (ph == PH_LOW)  && (cnt == '0);
    assign fin      = (ph == PH_HIGH) && (cnt == '0);

endmodule

// File: rtl/nfr_rb_watch.sv
`timescale 1ns/1ps
// nfr_rb_watch: synchronises the ready/busy pin and, once armed, waits
// for ready. The first GUARD clocks are ignored so the device has time to
// pull the line low. Reports expired after limit clocks without ready.
// Assumes GUARD fits in LIMIT_W bits.
module nfr_rb_watch #(
    parameter int GUARD   = 4,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               rb_pin,
    output logic               rb_level,
    output logic               ready,
    output logic               expired
);
    logic [1:0]         sync_q;
    logic               active;
    logic [LIMIT_W-1:0] cnt;
    logic               guard_ok;

    // Two-stage synchroniser for the asynchronous ready/busy pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
        end else begin
            sync_q <= {sync_q[0], rb_pin};
        end
    end

    assign rb_level = sync_q[1];
    assign guard_ok = (cnt >= LIMIT_W'(GUARD));
    assign ready    = active && guard_ok && rb_level;
    assign expired  = active && !ready && (cnt >= limit);

    // Wait window: counts clocks from arm until ready or the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (arm) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (ready || expired) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nfr_page_reader.sv
`timescale 1ns/1ps
// nfr_page_reader: sequences a NAND page read (setup, four address cycles,
// confirm), waits for ready with a timeout, then streams the page from a
// start column to the last column. In-page column jumps are supported.
// Assumes PAGE_BYTES <= 65536 and all strobe widths >= 1 clock.
module nfr_page_reader #(
    parameter int PAGE_BYTES = 2112,
    parameter int WE_LO      = 2,
    parameter int WE_HI      = 2,
    parameter int RE_LO      = 2,
    parameter int RE_HI      = 2,
    parameter int GUARD      = 4,
    parameter int LIMIT_W    = 16,
    localparam int COL_W     = $clog2(PAGE_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [15:0]        req_row,
    input  logic [COL_W-1:0]   req_col,
    input  logic               jump_valid,
    input  logic [COL_W-1:0]   jump_col,
    input  logic [LIMIT_W-1:0] busy_limit,
    output logic               busy,
    output logic               done,
    output logic               timeout,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic [COL_W-1:0]   out_col,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_we_n,
    output logic               nand_re_n,
    output logic [7:0]         nand_io_out,
    output logic               nand_io_oe,
    input  logic [7:0]         nand_io_in,
    input  logic               nand_rb
);
    import nfr_pkg::*;

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

    seq_state_t       state;
    logic [2:0]       step;
    logic             seq_jump;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic             jmp_pend;
    logic [COL_W-1:0] jmp_col;
    logic             at_end;
    logic             out_valid_q;
    logic [7:0]       out_data_q;
    logic [COL_W-1:0] out_col_q;
    logic             done_q;
    logic             timeout_q;

    logic             we_start, we_idle, we_strobe_n, we_sample, we_fin;
    logic             re_start, re_idle, re_strobe_n, re_sample, re_fin;
    logic             arm_wait, rdy_seen, wait_expired, rb_level_w;
    logic [2:0]       last_step;
    bus_word_t        cur_word;

    // Write strobe for command and address cycles.
    nfr_strobe #(.LO(WE_LO), .HI(WE_HI)) we_gen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (we_start),
        .idle     (we_idle),
        .strobe_n (we_strobe_n),
        .sample   (we_sample),
        .fin      (we_fin)
    );

    // Read strobe for data bytes.
    nfr_strobe #(.LO(RE_LO), .HI(RE_HI)) re_gen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (re_start),
        .idle     (re_idle),
        .strobe_n (re_strobe_n),
        .sample   (re_sample),
        .fin      (re_fin)
    );

    // Ready/busy wait with timeout.
    nfr_rb_watch #(.GUARD(GUARD), .LIMIT_W(LIMIT_W)) rb_watch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm_wait),
        .limit    (busy_limit),
        .rb_pin   (nand_rb),
        .rb_level (rb_level_w),
        .ready    (rdy_seen),
        .expired  (wait_expired)
    );

    // Select the bus word of the current sequence step.
    always_comb begin
        if (seq_jump) begin
            cur_word  = jump_word(step, 16'(col_q));
            last_step = JMP_LAST_STEP;
        end else begin
            cur_word  = read_word(step, 16'(col_q), 16'(row_q));
            last_step = RD_LAST_STEP;
        end
    end

    assign we_start = (state == ST_ISSUE) && we_idle;
    assign re_start = (state == ST_READ) && re_idle;
    assign arm_wait = (state == ST_ISSUE) && we_fin && (step == last_step) && !seq_jump;

    // Main sequencer: issue, wait for ready, stream, jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            step        <= 3'd0;
            seq_jump    <= 1'b0;
            col_q       <= '0;
            row_q       <= '0;
            jmp_pend    <= 1'b0;
            jmp_col     <= '0;
            at_end      <= 1'b0;
            out_valid_q <= 1'b0;
            out_data_q  <= 8'h00;
            out_col_q   <= '0;
            done_q      <= 1'b0;
            timeout_q   <= 1'b0;
        end else begin
            out_valid_q <= 1'b0;
            done_q      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        row_q     <= req_row;
                        col_q     <= req_col;
                        step      <= 3'd0;
                        seq_jump  <= 1'b0;
                        jmp_pend  <= 1'b0;
                        timeout_q <= 1'b0;
                        state     <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (we_fin) begin
                        if (step == last_step) begin
                            step  <= 3'd0;
                            state <= seq_jump ? ST_READ : ST_WAIT;
                        end else begin
                            step <= step + 3'd1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rdy_seen) begin
                        at_end <= 1'b0;
                        state  <= ST_READ;
                    end else if (wait_expired) begin
                        timeout_q <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (re_sample) begin
                        out_valid_q <= 1'b1;
                        out_data_q  <= nand_io_in;
                        out_col_q   <= col_q;
                        at_end      <= (col_q >= LAST_COL);
                        if (col_q < LAST_COL) begin
                            col_q <= col_q + 1'b1;
                        end
                    end
                    if (re_fin) begin
                        if (jmp_pend) begin
                            col_q    <= jmp_col;
                            jmp_pend <= 1'b0;
                            seq_jump <= 1'b1;
                            step     <= 3'd0;
                            at_end   <= 1'b0;
                            state    <= ST_ISSUE;
                        end else if (at_end) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                    if (jump_valid) begin
                        jmp_pend <= 1'b1;
                        jmp_col  <= jump_col;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign done        = done_q;
    assign timeout     = timeout_q;
    assign out_valid   = out_valid_q;
    assign out_data    = out_data_q;
    assign out_col     = out_col_q;
    assign nand_we_n   = we_strobe_n;
    assign nand_re_n   = re_strobe_n;
    assign nand_io_oe  = (state == ST_ISSUE);
    assign nand_cle    = (state == ST_ISSUE) && cur_word.cle;
    assign nand_ale    = (state == ST_ISSUE) && cur_word.ale;
    assign nand_io_out = (state == ST_ISSUE) ? cur_word.val : 8'h00;

endmodule

// File: rtl/nfr_page_reader_chk.sv
`timescale 1ns/1ps
// nfr_page_reader_chk: property checks on the sequencer's pins, bound
// into every instance. Strobe widths are checked with run counters.
module nfr_page_reader_chk #(
    parameter int WE_LO = 2,
    parameter int RE_LO = 2
) (
    input logic clk,
    input logic rst_n,
    input logic we_n,
    input logic re_n,
    input logic cle,
    input logic ale,
    input logic io_oe,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic out_valid,
    input logic rb_level
);
    logic [15:0] we_run, re_run;

    // Count the clocks each strobe has been low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= '0;
            re_run <= '0;
        end else begin
            we_run <= we_n ? 16'd0 : we_run + 16'd1;
            re_run <= re_n ? 16'd0 : re_run + 16'd1;
        end
    end

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (we_n && re_n && !busy && !timeout && !out_valid && !io_oe));

    // R1
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R2
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run == 16'(WE_LO)));

    // R2
    re_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(re_n) |-> (re_run == 16'(RE_LO)));

    // R3
    rb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |-> rb_level);

    // R11
    bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (we_n && re_n && !io_oe));

    // R4
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4
    done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    timeout_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (!busy && !done));

endmodule

bind nfr_page_reader nfr_page_reader_chk #(.WE_LO(WE_LO), .RE_LO(RE_LO)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .io_oe     (nand_io_oe),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .out_valid (out_valid),
    .rb_level  (rb_level_w)
);

// File: tb/nfr_page_reader_tb_top.sv
`timescale 1ns/1ps
module nfr_page_reader_tb_top;

    localparam int PB    = 16;
    localparam int CW    = $clog2(PB);
    localparam int T_WLO = 2;
    localparam int T_WHI = 1;
    localparam int T_RLO = 2;
    localparam int T_RHI = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [15:0]   req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic          jump_valid = 1'b0;
    logic [CW-1:0] jump_col = '0;
    logic [15:0]   busy_limit = 16'd200;
    logic          busy, done, timeout, out_valid;
    logic [7:0]    out_data;
    logic [CW-1:0] out_col;
    logic          nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]    nand_io_out;
    logic [7:0]    m_io;
    logic          m_rb;

    always #4 clk = ~clk;

    nfr_page_reader #(
        .PAGE_BYTES(PB), .WE_LO(T_WLO), .WE_HI(T_WHI),
        .RE_LO(T_RLO), .RE_HI(T_RHI), .GUARD(3), .LIMIT_W(16)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
        .req_col(req_col), .jump_valid(jump_valid), .jump_col(jump_col),
        .busy_limit(busy_limit), .busy(busy), .done(done), .timeout(timeout),
        .out_valid(out_valid), .out_data(out_data), .out_col(out_col),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(m_io), .nand_rb(m_rb)
    );

    function automatic logic [7:0] pat(input logic [15:0] r, input int c);
        return (r[7:0] ^ r[15:8]) + 8'(c * 7) + 8'd1;
    endfunction

    // ---------------- device model and monitor (one process) ----------
    logic        clr_mon = 1'b0;
    int          m_busy_len = 10;
    int          rb_left, log_n, rx_n, done_n, bad_re, re_lo_bad, re_per_min;
    int          re_run, re_gap, acnt, col_ptr;
    logic [9:0]  log_q [0:31];
    logic [7:0]  rx_data [0:63];
    int          rx_col [0:63];
    logic [15:0] a_col, a_row, m_row;
    logic        prev_we, prev_re;

    assign m_rb = (rb_left == 0);

    always @(negedge clk) begin
        if (!rst_n || clr_mon) begin
            if (!rst_n) begin
                rb_left = 0; m_io = 8'h00; col_ptr = 0;
                a_col = '0; a_row = '0; m_row = '0; acnt = 0;
            end
            log_n = 0; rx_n = 0; done_n = 0; bad_re = 0; re_lo_bad = 0;
            re_per_min = 999; re_run = 0; re_gap = -1;
            prev_we = 1'b1; prev_re = 1'b1;
        end else begin
            if (rb_left != 0) rb_left = rb_left - 1;
            if (!prev_we && nand_we_n) begin
                if (log_n < 32) log_q[log_n] = {nand_cle, nand_ale, nand_io_out};
                log_n = log_n + 1;
                if (nand_cle) begin
                    case (nand_io_out)
                        8'h00, 8'h05: acnt = 0;
                        8'h30: begin rb_left = m_busy_len; m_row = a_row; col_ptr = int'(a_col); end
                        8'hE0: col_ptr = int'(a_col);
                        default: ;
                    endcase
                end else if (nand_ale) begin
                    case (acnt)
                        0: a_col[7:0]  = nand_io_out;
                        1: a_col[15:8] = nand_io_out;
                        2: a_row[7:0]  = nand_io_out;
                        3: a_row[15:8] = nand_io_out;
                        default: ;
                    endcase
                    acnt = acnt + 1;
                end
            end
            if (re_gap >= 0) re_gap = re_gap + 1;
            if (prev_re && !nand_re_n) begin
                if (rb_left != 0) bad_re = bad_re + 1;
                m_io = pat(m_row, col_ptr);
                if (re_gap > 0 && re_gap < re_per_min) re_per_min = re_gap;
                re_gap = 0;
            end
            if (!nand_re_n) re_run = re_run + 1;
            if (!prev_re && nand_re_n) begin
                if (re_run != T_RLO) re_lo_bad = re_lo_bad + 1;
                re_run = 0;
                col_ptr = col_ptr + 1;
            end
            if (out_valid) begin
                if (rx_n < 64) begin rx_data[rx_n] = out_data; rx_col[rx_n] = int'(out_col); end
                rx_n = rx_n + 1;
            end
            if (done) done_n = done_n + 1;
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    // ---------------- checking infrastructure ----------------
    int err_n = 0;
    int chk_n = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        chk_n++;
        if (!ok) begin
            err_n++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_mon();
        @(posedge clk); #1 clr_mon = 1'b1;
        @(posedge clk); #1 clr_mon = 1'b0;
    endtask

    task automatic issue(input logic [15:0] r, input int c, input int bl);
        m_busy_len = bl;
        settle();
        req_valid = 1'b1; req_row = r; req_col = CW'(c);
        settle();
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(input int maxc);
        int n;
        n = 0;
        while (busy && n < maxc) begin settle(); n++; end
        chk(n < maxc, "R4 completion", n, maxc);
        settle();
    endtask

    task automatic check_read_log(input logic [15:0] r, input int c, input string tag);
        chk(log_n == 6, {tag, " cycle count"}, log_n, 6);
        chk(log_q[0] == {2'b10, 8'h00}, {tag, " setup cmd"}, int'(log_q[0]), 10'h200);
        chk(log_q[1] == {2'b01, 8'(c)}, {tag, " col low"}, int'(log_q[1]), int'({2'b01, 8'(c)}));
        chk(log_q[2] == {2'b01, 8'h00}, {tag, " col high"}, int'(log_q[2]), 10'h100);
        chk(log_q[3] == {2'b01, r[7:0]}, {tag, " row low"}, int'(log_q[3]), int'({2'b01, r[7:0]}));
        chk(log_q[4] == {2'b01, r[15:8]}, {tag, " row high"}, int'(log_q[4]), int'({2'b01, r[15:8]}));
        chk(log_q[5] == {2'b10, 8'h30}, {tag, " confirm cmd"}, int'(log_q[5]), 10'h230);
    endtask

    task automatic check_stream(input logic [15:0] r, input int c);
        int bad;
        bad = 0;
        for (int i = 0; i < rx_n && i < 64; i++) begin
            if (rx_col[i] != c + i || rx_data[i] != pat(r, c + i)) bad++;
        end
        chk(rx_n == PB - c, "R4 byte count", rx_n, PB - c);
        chk(bad == 0, "R4 data/column order", bad, 0);
        chk(done_n == 1, "R4 done pulse", done_n, 1);
    endtask

    // Vectors: {row[15:0], start col[15:0], busy length[15:0]}
    localparam int NV = 4;
    localparam logic [47:0] VEC [NV] = '{
        48'h1234_0000_0014,
        48'hABCD_0005_0028,
        48'h00FF_000F_0008,
        48'h8001_0009_003C
    };

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", err_n + 1, chk_n + 1);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (4) settle();
        // R9: reset state
        chk(nand_we_n && nand_re_n, "R9 strobes high in reset", {nand_we_n, nand_re_n}, 3);
        chk(!nand_cle && !nand_ale && !nand_io_oe, "R9 latches low", {nand_cle, nand_ale, nand_io_oe}, 0);
        chk(!busy && !timeout && !out_valid && !done, "R9 status low", {busy, timeout, out_valid, done}, 0);
        rst_n = 1'b1;
        settle();
        chk(!busy && nand_we_n && nand_re_n, "R9 after release", {busy, nand_we_n, nand_re_n}, 3);

        // Vector loop: R1, R2, R3, R4
        for (int v = 0; v < NV; v++) begin
            logic [15:0] r;
            int c, bl;
            r  = VEC[v][47:32];
            c  = int'(VEC[v][31:16]);
            bl = int'(VEC[v][15:0]);
            clear_mon();
            issue(r, c, bl);
            wait_idle(2000);
            check_read_log(r, c, "R1");
            check_stream(r, c);
            chk(re_lo_bad == 0, "R2 read strobe low width", re_lo_bad, 0);
            chk(rx_n < 2 || re_per_min >= T_RLO + T_RHI, "R2 read strobe period", re_per_min, T_RLO + T_RHI);
            chk(bad_re == 0, "R3 strobe while busy", bad_re, 0);
            chk(!timeout, "R8 no timeout on normal read", timeout, 0);
        end

        // R6: jump while idle does nothing
        clear_mon();
        settle();
        jump_valid = 1'b1; jump_col = CW'(3);
        settle();
        jump_valid = 1'b0;
        repeat (20) settle();
        chk(log_n == 0 && rx_n == 0, "R6 idle jump bus activity", log_n + rx_n, 0);
        chk(!busy, "R6 idle jump busy", busy, 0);

        // R5: two jumps inside one page
        begin
            int bad, n;
            clear_mon();
            issue(16'h0707, 2, 10);
            n = 0;
            while (rx_n < 2 && n < 2000) begin settle(); n++; end
            jump_valid = 1'b1; jump_col = CW'(10);
            settle();
            jump_valid = 1'b0;
            n = 0;
            while (!(rx_n > 0 && rx_col[rx_n-1] == 11) && n < 2000) begin settle(); n++; end
            jump_valid = 1'b1; jump_col = CW'(4);
            settle();
            jump_valid = 1'b0;
            wait_idle(3000);
            chk(log_n == 14, "R5 cycle count with two jumps", log_n, 14);
            chk(log_q[6] == {2'b10, 8'h05}, "R5 jump setup cmd", int'(log_q[6]), 10'h205);
            chk(log_q[7] == {2'b01, 8'd10}, "R5 jump col low", int'(log_q[7]), 10'h10A);
            chk(log_q[8] == {2'b01, 8'h00}, "R5 jump col high", int'(log_q[8]), 10'h100);
            chk(log_q[9] == {2'b10, 8'hE0}, "R5 jump confirm cmd", int'(log_q[9]), 10'h2E0);
            chk(log_q[11] == {2'b01, 8'd4}, "R5 second jump col", int'(log_q[11]), 10'h104);
            bad = 0;
            for (int i = 0; i < rx_n && i < 64; i++) begin
                if (rx_data[i] != pat(16'h0707, rx_col[i])) bad++;
                if (i > 0 && rx_col[i] != rx_col[i-1] + 1 && rx_col[i] != 10 && rx_col[i] != 4) bad++;
            end
            chk(rx_n > 0 && rx_col[0] == 2, "R5 first column", rx_col[0], 2);
            chk(bad == 0, "R5 data after jumps", bad, 0);
            chk(rx_n > 0 && rx_col[rx_n-1] == PB - 1, "R5 ends at last column", rx_col[rx_n-1], PB - 1);
            chk(done_n == 1, "R5 done once", done_n, 1);
        end

        // R10: next page read after jumps starts with full setup
        clear_mon();
        issue(16'h0505, 0, 12);
        wait_idle(2000);
        chk(log_q[0] == {2'b10, 8'h00}, "R10 setup after jumps", int'(log_q[0]), 10'h200);
        check_read_log(16'h0505, 0, "R10");
        check_stream(16'h0505, 0);

        // R7: request while busy ignored
        clear_mon();
        issue(16'h2222, 8, 15);
        req_valid = 1'b1; req_row = 16'h3333; req_col = CW'(1);
        settle();
        req_valid = 1'b0;
        wait_idle(2000);
        check_read_log(16'h2222, 8, "R7");
        check_stream(16'h2222, 8);

        // R8: ready timeout and clear on next request
        clear_mon();
        busy_limit = 16'd50;
        issue(16'h4444, 3, 500);
        wait_idle(2000);
        chk(timeout, "R8 timeout raised", timeout, 1);
        chk(rx_n == 0 && done_n == 0, "R8 no data or done", rx_n + done_n, 0);
        chk(log_n == 6, "R8 sequence sent", log_n, 6);
        busy_limit = 16'd200;
        clear_mon();
        issue(16'h4444, 3, 10);
        chk(!timeout && busy, "R8 timeout cleared on accept", {timeout, busy}, 1);
        wait_idle(2000);
        check_stream(16'h4444, 3);

        // R9: reset in the middle of streaming
        begin
            int n;
            clear_mon();
            issue(16'h6060, 0, 10);
            n = 0;
            while (rx_n < 3 && n < 2000) begin settle(); n++; end
            rst_n = 1'b0;
            settle();
            settle();
            chk(!busy && nand_we_n && nand_re_n && !nand_io_oe, "R9 mid-read reset",
                {busy, nand_we_n, nand_re_n, nand_io_oe}, 6);
            chk(!out_valid && !timeout, "R9 mid-read reset outputs", {out_valid, timeout}, 0);
            rst_n = 1'b1;
            settle();
        end

        $display("Result: errors=%0d of %0d checks", err_n, chk_n);
        $finish;
    end

endmodule